// File: doc/BRIEF.md
# Channel Control Pointer Register Port

This block is the 32-bit software access port of one command channel's control area. The engine that fetches commands owns three 40-bit pointers: the put pointer, the get pointer and the last-main-buffer get pointer. Software can only reach them one 32-bit word at a time. Read shadows keep those word accesses coherent. Reading a pointer's low word latches that pointer's upper eight bits in the same cycle, and the later read of the high word returns the latched copy. A write shadow does the same for the put pointer: software writes the high byte first, then writes the low word, which commits all 40 bits in one step.

The port also exposes several read-only views: the engine's reference counter, a current-get view that follows the subroutine state, the ring read index, and a software-owned ring write index. Ring mode selects who may write what. With ring mode off, software writes the put pointer directly. With ring mode on, the put pointer is locked against software and only the ring write index accepts writes.

The engine is outside this block. Its live values arrive on input ports, and it loads a new put pointer through a strobe. Read data is registered and appears one cycle after the request.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset, `rsp_rdata_o`, `put_o`, `ring_put_o`, the put write shadow and all three read shadows are zero.
- R2: A read at 0x044 returns `get_i[31:0]` in the following cycle and latches `get_i[39:32]` into the get read shadow. A read at 0x060 returns that shadow in bits 7:0, even if `get_i` has changed since.
- R3: A read at 0x058 returns `mget_i[31:0]` and latches `mget_i[39:32]` and `mget_valid_i`. A read at 0x05C returns the latched high bits in bits 7:0 and the latched valid flag in bit 8.
- R4: A read at 0x040 returns `put_o[31:0]` and latches `put_o[39:32]`. A read at 0x04C returns that latch in bits 7:0.
- R5: With ring mode off, a write at 0x04C changes only the put write shadow, so `put_o` is unchanged. A later write at 0x040 sets `put_o` to {write shadow, write data}.
- R6: With ring mode on, writes at 0x040 and 0x04C change neither `put_o` nor the write shadow.
- R7: With ring mode on, a write at 0x08C sets `ring_put_o` to `req_wdata_i[IDX_W-1:0]`. With ring mode off, that write is ignored. Reads at 0x08C and 0x088 return `ring_put_o` and `ring_get_i`, zero-extended.
- R8: A read at 0x054 returns `subr_ret_i` while `subr_active_i` is 1, and `get_i[31:0]` otherwise.
- R9: A read at 0x048 returns `ref_i`.
- R10: A read at any other address, including addresses that are not word-aligned, returns 0. Writes to read-only or unmapped addresses change no state.
- R11: `put_load_i` sets `put_o` to `put_load_val_i` on the next edge and takes priority over a software commit. A put-low read in the same cycle returns, and latches, the value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_mode_i | input | 1 | Ring-index submission mode enabled |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset in the control area |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, valid the cycle after a read |
| get_i | input | 40 | Live get pointer |
| mget_i | input | 40 | Live last-main-buffer get pointer |
| mget_valid_i | input | 1 | Last-main pointer valid |
| ref_i | input | 32 | Reference counter |
| subr_active_i | input | 1 | Subroutine active |
| subr_ret_i | input | 32 | Subroutine return address |
| ring_get_i | input | 8 | Ring read index |
| put_load_i | input | 1 | Engine put-pointer load strobe |
| put_load_val_i | input | 40 | Engine put-pointer load value |
| put_o | output | 40 | Put pointer |
| ring_put_o | output | 8 | Ring write index |

## Verification
The case that needs care is an engine put load that lands in the same cycle as a software read of the put low word. The read must return the pre-load low word and latch the pre-load high byte, while the pointer itself takes the new value. The bench sets up this case in ring mode: it raises the load strobe and the read request at the same falling edge. It then checks the returned word against the old pointer, `put_o` against the new pointer, and a subsequent high-word read against the old high byte. Sweeps over every offset, in both modes, confirm the remaining decode and lock-out behaviour against an arithmetic model.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
  localparam int PTR_W = 40;
  localparam int LO_W  = 32;
  localparam int HI_W  = PTR_W - LO_W;

  localparam int RS_PUT_LO  = 0;
  localparam int RS_GET_LO  = 1;
  localparam int RS_REF     = 2;
  localparam int RS_PUT_HI  = 3;
  localparam int RS_CUR_GET = 4;
  localparam int RS_MGET_LO = 5;
  localparam int RS_MGET_HI = 6;
  localparam int RS_GET_HI  = 7;
  localparam int RS_RGET    = 8;
  localparam int RS_RPUT    = 9;
  localparam int N_REGS     = 10;

  function automatic logic [7:0] reg_offset(input int idx);
    case (idx)
      RS_PUT_LO:  return 8'h40;
      RS_GET_LO:  return 8'h44;
      RS_REF:     return 8'h48;
      RS_PUT_HI:  return 8'h4C;
      RS_CUR_GET: return 8'h54;
      RS_MGET_LO: return 8'h58;
      RS_MGET_HI: return 8'h5C;
      RS_GET_HI:  return 8'h60;
      RS_RGET:    return 8'h88;
      default:    return 8'h8C;
    endcase
  endfunction
endpackage

// File: rtl/chan_ctl_decode.sv
module chan_ctl_decode
  import chan_ctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_REGS-1:0] sel_o
);
  for (genvar gi = 0; gi < N_REGS; gi++) begin : g_sel
    assign sel_o[gi] = (addr_i == ADDR_W'(reg_offset(gi)));
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(sel_o)); // R10
  end
endmodule

// File: rtl/chan_ctl_hi_shadow.sv
module chan_ctl_hi_shadow #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  AST_SHADOW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> q_o == $past(d_i)); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o)); // R2
endmodule

// File: rtl/chan_ctl_put_reg.sv
module chan_ctl_put_reg
  import chan_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_we_i,
  input  logic             lo_we_i,
  input  logic [LO_W-1:0]  wdata_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  output logic [PTR_W-1:0] put_o
);
  logic [HI_W-1:0] ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ws_q <= '0;
    else if (hi_we_i) ws_q <= wdata_i[HI_W-1:0];
  end

  // engine load wins over a software commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      put_o <= '0;
    else if (load_i)  put_o <= load_val_i;
    else if (lo_we_i) put_o <= {ws_q, wdata_i};
  end

  AST_PUT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i && !load_i |=> put_o == {$past(ws_q), $past(wdata_i)}); // R5
  AST_PUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> put_o == $past(load_val_i)); // R11
  AST_PUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !lo_we_i |=> $stable(put_o)); // R5
endmodule

// File: rtl/chan_ctl_regs.sv
module chan_ctl_regs
  import chan_ctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ring_mode_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rsp_rdata_o,
  input  logic [39:0]       get_i,
  input  logic [39:0]       mget_i,
  input  logic              mget_valid_i,
  input  logic [31:0]       ref_i,
  input  logic              subr_active_i,
  input  logic [31:0]       subr_ret_i,
  input  logic [IDX_W-1:0]  ring_get_i,
  input  logic              put_load_i,
  input  logic [39:0]       put_load_val_i,
  output logic [39:0]       put_o,
  output logic [IDX_W-1:0]  ring_put_o
);
  localparam int MS_W = HI_W + 1;

  logic [N_REGS-1:0] sel;
  logic              rd, wr, put_wr_ok;
  logic [HI_W-1:0]   put_rs, get_rs;
  logic [MS_W-1:0]   mget_rs;
  logic [31:0]       reg_val [N_REGS];
  logic [31:0]       rd_val;

  assign rd        = req_valid_i & ~req_write_i;
  assign wr        = req_valid_i & req_write_i;
  assign put_wr_ok = wr & ~ring_mode_i;

  chan_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(req_addr_i), .sel_o(sel));

  chan_ctl_hi_shadow #(.W(HI_W)) u_put_rs (
    .clk_i, .rst_ni, .cap_i(rd & sel[RS_PUT_LO]),
    .d_i(put_o[PTR_W-1:LO_W]), .q_o(put_rs));
  chan_ctl_hi_shadow #(.W(HI_W)) u_get_rs (
    .clk_i, .rst_ni, .cap_i(rd & sel[RS_GET_LO]),
    .d_i(get_i[PTR_W-1:LO_W]), .q_o(get_rs));
  chan_ctl_hi_shadow #(.W(MS_W)) u_mget_rs (
    .clk_i, .rst_ni, .cap_i(rd & sel[RS_MGET_LO]),
    .d_i({mget_valid_i, mget_i[PTR_W-1:LO_W]}), .q_o(mget_rs));

  chan_ctl_put_reg u_put (
    .clk_i, .rst_ni,
    .hi_we_i(put_wr_ok & sel[RS_PUT_HI]),
    .lo_we_i(put_wr_ok & sel[RS_PUT_LO]),
    .wdata_i(req_wdata_i),
    .load_i(put_load_i),
    .load_val_i(put_load_val_i),
    .put_o(put_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ring_put_o <= '0;
    else if (wr & sel[RS_RPUT] & ring_mode_i)    ring_put_o <= req_wdata_i[IDX_W-1:0];
  end

  assign reg_val[RS_PUT_LO]  = put_o[LO_W-1:0];
  assign reg_val[RS_GET_LO]  = get_i[LO_W-1:0];
  assign reg_val[RS_REF]     = ref_i;
  assign reg_val[RS_PUT_HI]  = 32'(put_rs);
  assign reg_val[RS_CUR_GET] = subr_active_i ? subr_ret_i : get_i[LO_W-1:0];
  assign reg_val[RS_MGET_LO] = mget_i[LO_W-1:0];
  assign reg_val[RS_MGET_HI] = 32'(mget_rs);
  assign reg_val[RS_GET_HI]  = 32'(get_rs);
  assign reg_val[RS_RGET]    = 32'(ring_get_i);
  assign reg_val[RS_RPUT]    = 32'(ring_put_o);

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (sel[i]) rd_val |= reg_val[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rsp_rdata_o <= '0;
    else if (rd)  rsp_rdata_o <= rd_val;
  end

  AST_PUT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_mode_i && wr && (sel[RS_PUT_LO] || sel[RS_PUT_HI]) && !put_load_i
    |=> $stable(put_o)); // R6
  AST_RING_PUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ring_mode_i && wr |=> $stable(ring_put_o)); // R7
  AST_CUR_GET_SUBR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel[RS_CUR_GET] && subr_active_i |=> rsp_rdata_o == $past(subr_ret_i)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel == '0 |=> rsp_rdata_o == 32'd0); // R10
endmodule

// File: tb/chan_ctl_regs_test.sv
`timescale 1ns/1ps
module chan_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ring_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [39:0] get_v = '0;
  logic [39:0] mget_v = '0;
  logic        mget_valid = 1'b0;
  logic [31:0] ref_v = '0;
  logic        subr_active = 1'b0;
  logic [31:0] subr_ret = '0;
  logic [7:0]  ring_get = '0;
  logic        put_load = 1'b0;
  logic [39:0] put_load_val = '0;
  logic [39:0] put_o;
  logic [7:0]  ring_put_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [39:0] m_put = '0;
  logic [7:0]  m_ws = '0, m_put_rs = '0, m_get_rs = '0, m_ring_put = '0;
  logic [8:0]  m_mget_rs = '0;

  always #2 clk = ~clk;

  chan_ctl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .ring_mode_i(ring_mode),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata),
    .get_i(get_v), .mget_i(mget_v), .mget_valid_i(mget_valid), .ref_i(ref_v),
    .subr_active_i(subr_active), .subr_ret_i(subr_ret), .ring_get_i(ring_get),
    .put_load_i(put_load), .put_load_val_i(put_load_val),
    .put_o(put_o), .ring_put_o(ring_put_o));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h040: return "R4 put low";
      12'h044: return "R2 get low";
      12'h048: return "R9 ref";
      12'h04C: return "R4 put high";
      12'h054: return "R8 cur get";
      12'h058: return "R3 mget low";
      12'h05C: return "R3 mget high";
      12'h060: return "R2 get high";
      12'h088: return "R7 ring get";
      12'h08C: return "R7 ring put";
      default: return "R10 unmapped";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h040: return m_put[31:0];
      12'h044: return get_v[31:0];
      12'h048: return ref_v;
      12'h04C: return {24'd0, m_put_rs};
      12'h054: return subr_active ? subr_ret : get_v[31:0];
      12'h058: return mget_v[31:0];
      12'h05C: return {23'd0, m_mget_rs};
      12'h060: return {24'd0, m_get_rs};
      12'h088: return {24'd0, ring_get};
      12'h08C: return {24'd0, m_ring_put};
      default: return 32'd0;
    endcase
  endfunction

  task automatic do_read(input logic [11:0] a);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag_of(a), {32'd0, rsp_rdata}, {32'd0, e});
    if (a == 12'h040) m_put_rs = m_put[39:32];
    if (a == 12'h044) m_get_rs = get_v[39:32];
    if (a == 12'h058) m_mget_rs = {mget_valid, mget_v[39:32]};
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (!ring_mode && a == 12'h040) m_put = {m_ws, d};
    if (!ring_mode && a == 12'h04C) m_ws = d[7:0];
    if (ring_mode && a == 12'h08C) m_ring_put = d[7:0];
    check((a == 12'h040 || a == 12'h04C) ? (ring_mode ? "R6 put locked" : "R5 put write")
          : "R10 write ignored", {24'd0, put_o}, {24'd0, m_put});
    check(a == 12'h08C ? "R7 ring put write" : "R10 ring put untouched",
          {56'd0, ring_put_o}, {56'd0, m_ring_put});
  endtask

  task automatic read_sweep();
    for (int a = 0; a < 256; a++) do_read(12'(a));
    do_read(12'h440);
    do_read(12'hC4C);
  endtask

  task automatic set_live(input int k);
    get_v       = {8'(8'hA1 + k * 17), 32'h1357_9BDF ^ 32'(k * 32'h0101_0101)};
    mget_v      = {8'(8'h5E - k * 3), 32'hFEDC_0000 + 32'(k)};
    mget_valid  = k[0];
    ref_v       = 32'hC0DE_0000 + 32'(k);
    subr_active = k[1];
    subr_ret    = 32'h0BAD_F000 | 32'(k);
    ring_get    = 8'(k * 37);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rdata", {32'd0, rsp_rdata}, 64'd0);
    check("R1 put", {24'd0, put_o}, 64'd0);
    check("R1 ring put", {56'd0, ring_put_o}, 64'd0);
    set_live(0);
    do_read(12'h04C);
    do_read(12'h060);
    do_read(12'h05C);

    // R2 shadow keeps old high bits after live change
    set_live(1);
    do_read(12'h044);
    get_v[39:32] = 8'h3C;
    do_read(12'h060);

    // R5 high write then low commit
    do_write(12'h04C, 32'h0000_00E7);
    do_write(12'h040, 32'h8765_4320);
    // R6 ring mode lock, shadow unchanged
    ring_mode = 1'b1;
    do_write(12'h04C, 32'h0000_0011);
    do_write(12'h040, 32'h1111_1111);
    do_write(12'h08C, 32'hFFFF_FF5A);
    ring_mode = 1'b0;
    do_write(12'h040, 32'h0000_0400);
    do_write(12'h08C, 32'h0000_0003);

    // sweeps over live patterns and both modes
    for (int k = 2; k < 6; k++) begin
      set_live(k);
      ring_mode = k[0];
      for (int a = 0; a < 256; a++) do_write(12'(a), {8'(a), 8'(~a), 8'(a * 3), 8'(a + k)});
      read_sweep();
    end

    // R11 engine load coinciding with put low read
    ring_mode = 1'b1;
    @(negedge clk);
    put_load = 1'b1; put_load_val = 40'h9C_CAFE_D00C;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h040;
    @(negedge clk);
    put_load = 1'b0; req_valid = 1'b0;
    check("R11 read sees pre-load", {32'd0, rsp_rdata}, {32'd0, m_put[31:0]});
    check("R11 load applied", {24'd0, put_o}, {24'd0, 40'h9C_CAFE_D00C});
    m_put_rs = m_put[39:32];
    m_put = 40'h9C_CAFE_D00C;
    do_read(12'h04C);
    // R11 load beats software commit
    ring_mode = 1'b0;
    @(negedge clk);
    put_load = 1'b1; put_load_val = 40'h21_0000_0ABC;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_wdata = 32'h7777_7777;
    @(negedge clk);
    put_load = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    check("R11 load priority", {24'd0, put_o}, {24'd0, 40'h21_0000_0ABC});
    m_put = 40'h21_0000_0ABC;
    do_read(12'h040);
    do_read(12'h04C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule